// File: doc/BRIEF.md
# Timer Slave Mode Controller

This block decides when and how a 16-bit timer counter moves. It selects one of eight trigger sources to form the trigger signal, optionally delays that trigger by one clock so that a group of timers can act together, and converts the chosen operating mode into per-cycle count-enable, direction, clear and update-event strobes. A small counter with a programmable reload value is included so that the strobes can be seen acting on a real count.

Software sets the configuration through a single write strobe that carries a mode code, a trigger-select code and a sync bit. The mode is held in a state machine with seven states. ST_INTCLK counts every clock. ST_QUAD decodes quadrature inputs. ST_CLRWAIT counts every clock and clears on a trigger rising edge. ST_GATED counts while the trigger is high. ST_ARMED waits for a trigger rising edge. ST_RUNNING counts every clock after that start. ST_EDGECNT counts trigger rising edges.

There are three kinds of transition. A configuration write whose mode differs from the held mode moves the machine to that mode's entry state, and mode 110 enters ST_ARMED. A trigger rising edge moves ST_ARMED to ST_RUNNING. ST_RUNNING stays until the mode is changed again.

Top module: `tmr_slave_ctl`

## Requirements
- R1: The trigger is chosen by the select code. Codes 0 to 3 pick itr_i[0] to itr_i[3], code 4 picks ti1_edge_i, 5 picks ti1_filt_i, 6 picks ti2_filt_i and 7 picks etr_filt_i. With sync off, trgo_o equals the chosen source in the same cycle.
- R2: A configuration write updates the select code only if the held mode is 000 at that write. Otherwise the old select code is kept. Mode and sync bit are taken on every write, and a new mode acts from the next clock.
- R3: In mode 000 the count advances by one every clock. Counting up, it goes from reload_i to 0 and raises upd_evt_o in that step's cycle.
- R4: In mode 001 each change of ti2_filt_i gives one step, and changes of ti1_filt_i give none. The step counts up when, after the change, ti1_filt_i equals ti2_filt_i, and down otherwise.
- R5: In mode 010 each change of ti1_filt_i gives one step, and changes of ti2_filt_i give none. The step counts up when, after the change, ti1_filt_i differs from ti2_filt_i, and down otherwise.
- R6: In mode 011 each input's changes step using the rules of R4 and R5. When both inputs change in the same cycle there is no step.
- R7: In mode 100 the count advances every clock. A trigger rising edge raises cnt_clr_o and upd_evt_o in that cycle, and the count is 0 after the edge. The clear takes precedence over a coinciding wrap, which gives a single update strobe.
- R8: In mode 101 the count advances on each clock where the trigger is high. It holds its value, without clearing, while the trigger is low.
- R9: In mode 110 the count holds until a trigger rising edge and advances every clock from the following cycle on, whatever the trigger does. Leaving the mode and entering it again re-arms the wait.
- R10: In mode 111 the count advances once for each trigger rising edge. A trigger held high gives no further steps.
- R11: With the sync bit set, the trigger used by the modes and driven on trgo_o is the selected source delayed by exactly one clock.
- R12: Counting down goes from 0 to reload_i and raises upd_evt_o. cnt_dir_o is 1 during a down step and 0 during an up step.
- R13: While rst_n is low the count is 0 and held, and the mode and select code are 000. After release the block counts on every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_mode | input | 3 | Mode code |
| cfg_tsel | input | 3 | Trigger-select code |
| cfg_sync | input | 1 | One-cycle trigger delay enable |
| reload_i | input | 16 | Counter reload (top) value |
| itr_i | input | 4 | Internal trigger sources 0 to 3 |
| ti1_edge_i | input | 1 | Edge-detector output of input 1 |
| ti1_filt_i | input | 1 | Filtered input 1 level |
| ti2_filt_i | input | 1 | Filtered input 2 level |
| etr_filt_i | input | 1 | Filtered external trigger |
| cnt_en_o | output | 1 | Count step strobe for this cycle |
| cnt_dir_o | output | 1 | Step direction, 1 = down |
| cnt_clr_o | output | 1 | Counter clear strobe |
| upd_evt_o | output | 1 | Update event (clear or wrap) |
| trgo_o | output | 1 | Effective trigger, also sent to slave timers |
| count_o | output | 16 | Counter value |

## Verification
In the trigger-clear mode the counter steps on every clock, so a trigger rising edge can land in the cycle where the count sits at the reload value. In that cycle a clear and a wrap fall together. The bench runs the count up to the reload value and raises the trigger in that very cycle. It then expects cnt_clr_o and upd_evt_o both high for one cycle and a count of 0 afterwards, and compares this with a plain wrap and a clear in mid-count. A second collision is a change on both quadrature inputs in one cycle in mode 011. The sweep over all sixteen level transitions provokes it, and the bench expects no step there.

// File: rtl/tmr_slv_pkg.sv
package tmr_slv_pkg;

    localparam int TSEL_W = 3;
    localparam int NSRC   = 1 << TSEL_W;
    localparam int N_ITR  = 4;
    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        MD_INTCLK   = 3'd0,
        MD_ENC_B    = 3'd1,
        MD_ENC_A    = 3'd2,
        MD_ENC_AB   = 3'd3,
        MD_TRGCLR   = 3'd4,
        MD_GATE     = 3'd5,
        MD_TRGSTART = 3'd6,
        MD_EXTEDGE  = 3'd7
    } smode_e;

    typedef enum logic [2:0] {
        ST_INTCLK,
        ST_QUAD,
        ST_CLRWAIT,
        ST_GATED,
        ST_ARMED,
        ST_RUNNING,
        ST_EDGECNT
    } sstate_e;

endpackage

// File: rtl/tmr_trig_sel.sv
module tmr_trig_sel
    import tmr_slv_pkg::*;
#(
    parameter int SRC_N = NSRC,
    localparam int SEL_W = $clog2(SRC_N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SRC_N-1:0] src_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             sync_i,
    output logic             trg_o,
    output logic             trg_rise_o
);

    logic raw;
    logic dly_q;
    logic prev_q;

    assign raw = src_i[sel_i];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dly_q  <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            dly_q  <= raw;
            prev_q <= trg_o;
        end
    end

    assign trg_o      = sync_i ? dly_q : raw;
    assign trg_rise_o = trg_o & ~prev_q;

    AST_SYNC_LAG: assert property (@(posedge clk) disable iff (!rst_n) (sync_i && $past(rst_n)) |-> (trg_o == $past(raw))) else $error("sync lag"); // R11

endmodule

// File: rtl/tmr_quad_dec.sv
module tmr_quad_dec (
    input  logic clk,
    input  logic rst_n,
    input  logic a_i,
    input  logic b_i,
    input  logic use_a_i,
    input  logic use_b_i,
    output logic step_o,
    output logic down_o
);

    logic a_q;
    logic b_q;
    logic ea;
    logic eb;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= 1'b0;
            b_q <= 1'b0;
        end else begin
            a_q <= a_i;
            b_q <= b_i;
        end
    end

    assign ea = (a_i != a_q) & use_a_i;
    assign eb = (b_i != b_q) & use_b_i;

    always_comb begin
        step_o = 1'b0;
        down_o = 1'b0;
        if (ea && eb) begin
            step_o = 1'b0;
        end else if (ea) begin
            step_o = 1'b1;
            down_o = ~(a_i ^ b_i);
        end else if (eb) begin
            step_o = 1'b1;
            down_o = a_i ^ b_i;
        end
    end

    AST_QUAD_CLASH: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && use_a_i && use_b_i && (a_i != $past(a_i)) && (b_i != $past(b_i))) |-> !step_o) else $error("clash step"); // R6
    AST_QUAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ($past(rst_n) && $stable(a_i) && $stable(b_i)) |-> !step_o) else $error("quiet step"); // R4

endmodule

// File: rtl/tmr_slv_fsm.sv
module tmr_slv_fsm
    import tmr_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [TSEL_W-1:0] cfg_tsel,
    input  logic              cfg_sync,
    input  logic              trg_lvl_i,
    input  logic              trg_rise_i,
    input  logic              enc_step_i,
    input  logic              enc_down_i,
    output logic [TSEL_W-1:0] tsel_o,
    output logic              sync_o,
    output logic              use_a_o,
    output logic              use_b_o,
    output logic              step_o,
    output logic              down_o,
    output logic              clr_o
);

    sstate_e state_q;
    sstate_e state_d;
    smode_e  mode_q;
    logic    dir_q;

    function automatic sstate_e entry_of(input smode_e m);
        sstate_e s;
        unique case (m)
            MD_INTCLK:   s = ST_INTCLK;
            MD_ENC_B:    s = ST_QUAD;
            MD_ENC_A:    s = ST_QUAD;
            MD_ENC_AB:   s = ST_QUAD;
            MD_TRGCLR:   s = ST_CLRWAIT;
            MD_GATE:     s = ST_GATED;
            MD_TRGSTART: s = ST_ARMED;
            MD_EXTEDGE:  s = ST_EDGECNT;
        endcase
        return s;
    endfunction

    always_comb begin
        state_d = state_q;
        if (cfg_wr && (smode_e'(cfg_mode) != mode_q)) begin
            state_d = entry_of(smode_e'(cfg_mode));
        end else if (state_q == ST_ARMED && trg_rise_i) begin
            state_d = ST_RUNNING;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_INTCLK;
            mode_q  <= MD_INTCLK;
            tsel_o  <= '0;
            sync_o  <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (cfg_wr) begin
                mode_q <= smode_e'(cfg_mode);
                sync_o <= cfg_sync;
                if (mode_q == MD_INTCLK) begin
                    tsel_o <= cfg_tsel;
                end
            end
            if (state_q != ST_QUAD) begin
                dir_q <= 1'b0;
            end else if (enc_step_i) begin
                dir_q <= enc_down_i;
            end
        end
    end

    always_comb begin
        step_o = 1'b0;
        down_o = 1'b0;
        clr_o  = 1'b0;
        unique case (state_q)
            ST_INTCLK:  step_o = 1'b1;
            ST_QUAD: begin
                step_o = enc_step_i;
                down_o = enc_step_i ? enc_down_i : dir_q;
            end
            ST_CLRWAIT: begin
                step_o = 1'b1;
                clr_o  = trg_rise_i;
            end
            ST_GATED:   step_o = trg_lvl_i;
            ST_ARMED:   step_o = 1'b0;
            ST_RUNNING: step_o = 1'b1;
            ST_EDGECNT: step_o = trg_rise_i;
        endcase
    end

    assign use_a_o = (mode_q == MD_ENC_A) || (mode_q == MD_ENC_AB);
    assign use_b_o = (mode_q == MD_ENC_B) || (mode_q == MD_ENC_AB);

    AST_TSEL_LOCK: assert property (@(posedge clk) disable iff (!rst_n) (cfg_wr && mode_q != MD_INTCLK) |=> $stable(tsel_o)) else $error("tsel changed"); // R2
    AST_ARM_START: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_ARMED && trg_rise_i && !cfg_wr) |=> (state_q == ST_RUNNING)) else $error("no start"); // R9
    AST_RUN_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (state_q == ST_RUNNING && !cfg_wr) |=> (state_q == ST_RUNNING)) else $error("run dropped"); // R9

endmodule

// File: rtl/tmr_cnt_core.sv
module tmr_cnt_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             down_i,
    input  logic             clr_i,
    input  logic [CNT_W-1:0] reload_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);

    logic at_top;
    logic at_bot;

    assign at_top = (count_o == reload_i);
    assign at_bot = (count_o == '0);
    assign wrap_o = step_i & (down_i ? at_bot : at_top);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (clr_i) begin
            count_o <= '0;
        end else if (step_i) begin
            if (down_i) begin
                count_o <= at_bot ? reload_i : count_o - 1'b1;
            end else begin
                count_o <= at_top ? '0 : count_o + 1'b1;
            end
        end
    end

    AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n) clr_i |=> (count_o == '0)) else $error("clear"); // R7
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (step_i && !down_i && !clr_i && count_o == reload_i) |=> (count_o == '0)) else $error("up wrap"); // R3
    AST_DOWN_WRAP: assert property (@(posedge clk) disable iff (!rst_n) (step_i && down_i && !clr_i && count_o == '0) |=> (count_o == $past(reload_i))) else $error("down wrap"); // R12
    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!step_i && !clr_i) |=> $stable(count_o)) else $error("hold"); // R8

endmodule

// File: rtl/tmr_slave_ctl.sv
module tmr_slave_ctl
    import tmr_slv_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [MODE_W-1:0] cfg_mode,
    input  logic [TSEL_W-1:0] cfg_tsel,
    input  logic              cfg_sync,
    input  logic [CNT_W-1:0]  reload_i,
    input  logic [N_ITR-1:0]  itr_i,
    input  logic              ti1_edge_i,
    input  logic              ti1_filt_i,
    input  logic              ti2_filt_i,
    input  logic              etr_filt_i,
    output logic              cnt_en_o,
    output logic              cnt_dir_o,
    output logic              cnt_clr_o,
    output logic              upd_evt_o,
    output logic              trgo_o,
    output logic [CNT_W-1:0]  count_o
);

    logic [NSRC-1:0]   src_vec;
    logic [TSEL_W-1:0] tsel;
    logic              sync_en;
    logic              trg_rise;
    logic              use_a;
    logic              use_b;
    logic              enc_step;
    logic              enc_down;
    logic              wrap;

    assign src_vec = {etr_filt_i, ti2_filt_i, ti1_filt_i, ti1_edge_i, itr_i};

    tmr_trig_sel #(.SRC_N(NSRC)) u_trig (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_i      (src_vec),
        .sel_i      (tsel),
        .sync_i     (sync_en),
        .trg_o      (trgo_o),
        .trg_rise_o (trg_rise)
    );

    tmr_quad_dec u_quad (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_i     (ti1_filt_i),
        .b_i     (ti2_filt_i),
        .use_a_i (use_a),
        .use_b_i (use_b),
        .step_o  (enc_step),
        .down_o  (enc_down)
    );

    tmr_slv_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_wr     (cfg_wr),
        .cfg_mode   (cfg_mode),
        .cfg_tsel   (cfg_tsel),
        .cfg_sync   (cfg_sync),
        .trg_lvl_i  (trgo_o),
        .trg_rise_i (trg_rise),
        .enc_step_i (enc_step),
        .enc_down_i (enc_down),
        .tsel_o     (tsel),
        .sync_o     (sync_en),
        .use_a_o    (use_a),
        .use_b_o    (use_b),
        .step_o     (cnt_en_o),
        .down_o     (cnt_dir_o),
        .clr_o      (cnt_clr_o)
    );

    tmr_cnt_core #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .step_i   (cnt_en_o),
        .down_i   (cnt_dir_o),
        .clr_i    (cnt_clr_o),
        .reload_i (reload_i),
        .count_o  (count_o),
        .wrap_o   (wrap)
    );

    assign upd_evt_o = cnt_clr_o | wrap;

    AST_UPD_SOURCE: assert property (@(posedge clk) disable iff (!rst_n) upd_evt_o |=> (count_o == '0 || count_o == $past(reload_i))) else $error("update value"); // R7
    AST_RESET_ZERO: assert property (@(posedge clk) !rst_n |=> (count_o == '0)) else $error("reset count"); // R13

endmodule

// File: tb/tmr_slave_ctl_test.sv
module tmr_slave_ctl_test;

    localparam int CLK_PERIOD = 10;
    localparam int RELOAD     = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [2:0]  cfg_mode = '0;
    logic [2:0]  cfg_tsel = '0;
    logic        cfg_sync = 1'b0;
    logic [15:0] reload = 16'(RELOAD);
    logic [7:0]  src = '0;
    logic        cnt_en, cnt_dir, cnt_clr, upd_evt, trgo;
    logic [15:0] count;

    int checks = 0;
    int failures = 0;
    int expc = 0;
    int cur_mode = 0;
    bit trg_run = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_slave_ctl uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_mode(cfg_mode),
        .cfg_tsel(cfg_tsel), .cfg_sync(cfg_sync), .reload_i(reload),
        .itr_i(src[3:0]), .ti1_edge_i(src[4]), .ti1_filt_i(src[5]),
        .ti2_filt_i(src[6]), .etr_filt_i(src[7]),
        .cnt_en_o(cnt_en), .cnt_dir_o(cnt_dir), .cnt_clr_o(cnt_clr),
        .upd_evt_o(upd_evt), .trgo_o(trgo), .count_o(count)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int nxt(input int c, input bit down);
        if (down) return (c == 0) ? RELOAD : c - 1;
        return (c == RELOAD) ? 0 : c + 1;
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        src = '0;
        cfg_wr = 1'b0;
        tick();
        tick();
        check("R13 count in reset", int'(count), 0);
        rst_n = 1'b1;
        expc = 0;
        cur_mode = 0;
        trg_run = 0;
    endtask

    task automatic cfg(input int m, input int s, input int sy);
        cfg_mode = 3'(m);
        cfg_tsel = 3'(s);
        cfg_sync = 1'(sy);
        cfg_wr = 1'b1;
        if (cur_mode == 0 || cur_mode == 4 || (cur_mode == 6 && trg_run))
            expc = nxt(expc, 0);
        tick();
        cfg_wr = 1'b0;
        if (m != cur_mode) trg_run = 0;
        cur_mode = m;
    endtask

    // Bench model of the quadrature rules (R4, R5, R6)
    task automatic enc_model(input int m, input bit [1:0] o, input bit [1:0] n,
                             output bit st, output bit dn);
        bit e1, e2;
        e1 = (o[1] != n[1]) && (m == 2 || m == 3);
        e2 = (o[0] != n[0]) && (m == 1 || m == 3);
        st = 0;
        dn = 0;
        if (e1 && e2) st = 0;
        else if (e1) begin st = 1; dn = (n[1] == n[0]); end
        else if (e2) begin st = 1; dn = (n[1] != n[0]); end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        failures++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        // R13 reset then free counting, R3 wrap
        do_reset();
        for (int i = 0; i < 25; i++) begin
            #1;
            check("R3 cnt_en in mode 000", int'(cnt_en), 1);
            check("R3 upd at wrap", int'(upd_evt), (expc == RELOAD) ? 1 : 0);
            expc = nxt(expc, 0);
            tick();
            check("R3 count free run", int'(count), expc);
        end

        // R1 exhaustive select sweep
        for (int s = 0; s < 8; s++) begin
            cfg(0, s, 0);
            for (int j = 0; j < 8; j++) begin
                src = 8'(1 << j);
                #1;
                check("R1 trgo select", int'(trgo), (j == s) ? 1 : 0);
                src = '0;
                #1;
            end
        end

        // R2 select write ignored outside mode 000, R10 edge counting
        do_reset();
        cfg(0, 7, 0);
        cfg(7, 7, 0);
        cfg(7, 2, 0);
        src[2] = 1'b1;
        #1;
        check("R2 select kept", int'(trgo), 0);
        tick();
        check("R2 no count from ignored source", int'(count), expc);
        src[2] = 1'b0;
        for (int p = 1; p <= 4; p++) begin
            src[7] = 1'b1;
            #1;
            check("R10 step on rise", int'(cnt_en), 1);
            expc = nxt(expc, 0);
            tick();
            check("R10 count after rise", int'(count), expc);
            for (int h = 1; h < p; h++) begin
                #1;
                check("R10 no step on held level", int'(cnt_en), 0);
                tick();
            end
            src[7] = 1'b0;
            for (int l = 0; l < p; l++) tick();
            check("R10 count after pulse", int'(count), expc);
        end
        cfg(0, 7, 0);
        cfg(0, 2, 0);
        src[2] = 1'b1;
        #1;
        check("R2 select taken in mode 000", int'(trgo), 1);
        src[2] = 1'b0;

        // R11 one-cycle trigger delay
        do_reset();
        cfg(0, 7, 1);
        cfg(7, 7, 1);
        src[7] = 1'b1;
        #1;
        check("R11 trgo delayed", int'(trgo), 0);
        check("R11 no step before delay", int'(cnt_en), 0);
        tick();
        check("R11 trgo after one clock", int'(trgo), 1);
        check("R11 step after delay", int'(cnt_en), 1);
        check("R11 count not yet", int'(count), expc);
        expc = nxt(expc, 0);
        tick();
        check("R11 count after delayed edge", int'(count), expc);
        src[7] = 1'b0;
        tick();
        tick();
        check("R11 no extra count", int'(count), expc);

        // R8 gated mode
        do_reset();
        cfg(0, 5, 0);
        cfg(5, 5, 0);
        for (int i = 0; i < 20; i++) begin
            bit lv;
            lv = (((20'hB3C5E >> i) & 1) != 0);
            src[5] = lv;
            #1;
            check("R8 gated enable", int'(cnt_en), int'(lv));
            if (lv) expc = nxt(expc, 0);
            tick();
            check("R8 gated count", int'(count), expc);
        end
        src[5] = 1'b0;

        // R9 trigger start
        do_reset();
        cfg(0, 6, 0);
        cfg(6, 6, 0);
        for (int i = 0; i < 3; i++) tick();
        check("R9 armed holds", int'(count), expc);
        src[6] = 1'b1;
        tick();
        src[6] = 1'b0;
        trg_run = 1;
        check("R9 no step in start cycle", int'(count), expc);
        for (int i = 0; i < 4; i++) begin
            expc = nxt(expc, 0);
            tick();
            check("R9 runs after start", int'(count), expc);
        end
        cfg(7, 6, 0);
        cfg(6, 6, 0);
        for (int i = 0; i < 3; i++) tick();
        check("R9 re-armed after mode change", int'(count), expc);

        // R7 clear on trigger, and clear colliding with wrap
        do_reset();
        cfg(0, 4, 0);
        cfg(4, 4, 0);
        expc = nxt(expc, 0); tick();
        expc = nxt(expc, 0); tick();
        check("R7 runs in clear mode", int'(count), expc);
        src[4] = 1'b1;
        #1;
        check("R7 clear strobe", int'(cnt_clr), 1);
        check("R7 update on clear", int'(upd_evt), 1);
        tick();
        src[4] = 1'b0;
        expc = 0;
        check("R7 count cleared", int'(count), 0);
        while (expc != RELOAD) begin expc = nxt(expc, 0); tick(); end
        #1;
        check("R3 plain wrap update", int'(upd_evt), 1);
        check("R3 plain wrap no clear", int'(cnt_clr), 0);
        expc = nxt(expc, 0);
        tick();
        while (expc != RELOAD) begin expc = nxt(expc, 0); tick(); end
        check("R7 at reload before collision", int'(count), RELOAD);
        src[4] = 1'b1;
        #1;
        check("R7 collision clear", int'(cnt_clr), 1);
        check("R7 collision update", int'(upd_evt), 1);
        tick();
        src[4] = 1'b0;
        #1;
        check("R7 single update strobe", int'(upd_evt), 0);
        check("R7 collision result", int'(count), 0);
        expc = 1;
        tick();
        check("R7 counting resumes", int'(count), expc);

        // R4 R5 R6 R12 quadrature sweeps over all level transitions
        for (int m = 1; m <= 3; m++) begin
            bit [1:0] lv;
            do_reset();
            cfg(m, 0, 0);
            lv = 2'b00;
            for (int o = 0; o < 4; o++) begin
                for (int k = 0; k < 2; k++) begin
                    for (int n = 0; n < 4; n++) begin
                        bit [1:0] nv;
                        bit st, dn;
                        nv = (k == 0) ? 2'(o) : 2'(n);
                        enc_model(m, lv, nv, st, dn);
                        src[5] = nv[1];
                        src[6] = nv[0];
                        #1;
                        check((m == 1) ? "R4 step" : (m == 2) ? "R5 step" : "R6 step",
                              int'(cnt_en), int'(st));
                        if (st) begin
                            check("R12 direction", int'(cnt_dir), int'(dn));
                            expc = nxt(expc, dn);
                        end
                        tick();
                        check((m == 1) ? "R4 count" : (m == 2) ? "R5 count" : "R6 count",
                              int'(count), expc);
                        lv = nv;
                        if (k == 0) break;
                    end
                end
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule